// File: doc/BRIEF.md
# Ladder Bit Element Evaluator

This block evaluates a single ladder-logic bit instruction for several independent lanes at once. Each lane owns one memory bit, the rung state it last saw and the power-flow value it last passed on. On every scan strobe, each lane reads its incoming power flow, its 4-bit instruction code and its stored bit. It then produces the power flow that leaves the instruction and, for coil instructions, a new value of the bit. The contact instructions test the stored bit or the edges of the incoming power flow. The coil instructions write, latch, unlatch or edge-sense into the bit.

A separate power-cycle input models loss of controller power. Each lane has a retain flag. Bits whose retain flag is low are cleared on a power cycle, while retained bits keep their value. The remembered rung state and the outgoing power flow are always cleared on a power cycle. A scan controller drives the strobe once per program pass and places instructions in front of each lane. Rung parsing and program storage are handled outside this block.

Top module: `ladder_bit_unit`

## Requirements
- R1: After reset, every lane shows bit_q = 0 and rung_out = 0, and the remembered rung state is 0, so the first scan with power present counts as a rising edge.
- R2: While scan_en and pwr_cycle are both low, rung_out and bit_q hold their values, whatever the other inputs do.
- R3: Opcode 0 (open contact): on a scan, rung_out becomes rung_in AND the stored bit, and the bit is unchanged.
- R4: Opcode 1 (closed contact): on a scan, rung_out becomes rung_in AND NOT the stored bit, and the bit is unchanged.
- R5: Opcode 2 (rising contact): on a scan, rung_out is 1 only when rung_in is 1 and the rung_in of the previous scan was 0. The bit is unchanged.
- R6: Opcode 3 (falling contact): on a scan, rung_out is 1 only when rung_in is 0 and the rung_in of the previous scan was 1. The bit is unchanged.
- R7: Opcode 4 writes rung_in into the bit, and opcode 5 writes NOT rung_in into the bit.
- R8: Opcode 6 sets the bit when rung_in is 1, and opcode 7 clears the bit when rung_in is 1. Both leave the bit unchanged when rung_in is 0.
- R9: Opcode 8 sets the bit only on a 0-to-1 change of rung_in between scans. Opcode 9 clears the bit only on a 1-to-0 change. Otherwise the bit is left unchanged.
- R10: For coil opcodes 4 to 9 and for the undefined opcodes 10 to 15, rung_out becomes rung_in. The undefined opcodes leave the bit unchanged.
- R11: A pwr_cycle cycle clears the bit when retain is 0 and keeps it when retain is 1. It also clears rung_out and the remembered rung state. pwr_cycle takes priority over a simultaneous scan.
- R12: Every scan records rung_in as the remembered rung state, whatever the opcode, so the edge instructions compare against the previous scan of the same lane.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| scan_en | input | 1 | Scan strobe; each lane evaluates once in a cycle where it is high |
| pwr_cycle | input | 1 | Power-cycle event, one cycle wide |
| rung_in | input | LANES | Incoming power flow per lane |
| opcode | input | LANES*4 | Instruction code per lane, with lane 0 in bits 3:0 |
| retain | input | LANES | Per-lane retentive flag for the stored bit |
| rung_out | output | LANES | Outgoing power flow per lane, registered |
| bit_q | output | LANES | Stored memory bit per lane, registered |

## Verification
The hardest situation to reach is an edge instruction whose expected result depends on history that another instruction left behind. Examples are a rising contact scanned right after a coil left the remembered rung state high, or an edge coil scanned right after a power cycle cleared that state. The stimulus reaches these states by first running directed sequences that put each lane through a rise, a hold and a fall. It then runs a long random phase in which the opcode, the rung value, the scan strobe and occasional power cycles all change between scans. A per-lane behavioural model keeps its own history throughout.

// File: rtl/ladder_pkg.sv
package ladder_pkg;

  localparam int OP_W = 4;

  typedef enum logic [OP_W-1:0] {
    OP_TEST_ON   = 4'd0,
    OP_TEST_OFF  = 4'd1,
    OP_EDGE_UP   = 4'd2,
    OP_EDGE_DN   = 4'd3,
    OP_WRITE     = 4'd4,
    OP_WRITE_INV = 4'd5,
    OP_LATCH     = 4'd6,
    OP_UNLATCH   = 4'd7,
    OP_SET_UP    = 4'd8,
    OP_CLR_DN    = 4'd9
  } lad_op_e;

  typedef struct packed {
    logic stored;
    logic last_rung;
    logic flow;
  } lane_state_t;

  function automatic logic op_is_contact(input logic [OP_W-1:0] op);
    return op <= OP_W'(OP_EDGE_DN);
  endfunction

endpackage

// File: rtl/lad_rst_sync.sv
module lad_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/lad_contact.sv
module lad_contact
  import ladder_pkg::*;
(
  input  logic [OP_W-1:0] op,
  input  logic            rung,
  input  logic            stored,
  input  logic            last_rung,
  output logic            flow
);
  always_comb begin
    unique case (op)
      OP_W'(OP_TEST_ON):  flow = rung & stored;
      OP_W'(OP_TEST_OFF): flow = rung & ~stored;
      OP_W'(OP_EDGE_UP):  flow = rung & ~last_rung;
      OP_W'(OP_EDGE_DN):  flow = ~rung & last_rung;
      default:            flow = rung;
    endcase
  end
endmodule

// File: rtl/lad_coil.sv
module lad_coil
  import ladder_pkg::*;
(
  input  logic [OP_W-1:0] op,
  input  logic            rung,
  input  logic            stored,
  input  logic            last_rung,
  output logic            stored_nx
);
  logic rose;
  logic fell;

  always_comb begin
    rose = rung & ~last_rung;
    fell = ~rung & last_rung;
    unique case (op)
      OP_W'(OP_WRITE):     stored_nx = rung;
      OP_W'(OP_WRITE_INV): stored_nx = ~rung;
      OP_W'(OP_LATCH):     stored_nx = rung ? 1'b1 : stored;
      OP_W'(OP_UNLATCH):   stored_nx = rung ? 1'b0 : stored;
      OP_W'(OP_SET_UP):    stored_nx = rose ? 1'b1 : stored;
      OP_W'(OP_CLR_DN):    stored_nx = fell ? 1'b0 : stored;
      default:             stored_nx = stored;
    endcase
  end
endmodule

// File: rtl/lad_lane.sv
module lad_lane
  import ladder_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            scan_en,
  input  logic            pwr_cycle,
  input  logic            rung_in,
  input  logic [OP_W-1:0] op,
  input  logic            retain,
  output logic            rung_out,
  output logic            bit_q
);
  lane_state_t st_q;
  lane_state_t st_d;
  logic        ld_en;
  logic        contact_flow;
  logic        coil_bit;

  lad_contact u_contact (
    .op        (op),
    .rung      (rung_in),
    .stored    (st_q.stored),
    .last_rung (st_q.last_rung),
    .flow      (contact_flow)
  );

  lad_coil u_coil (
    .op        (op),
    .rung      (rung_in),
    .stored    (st_q.stored),
    .last_rung (st_q.last_rung),
    .stored_nx (coil_bit)
  );

  always_comb begin
    ld_en = scan_en | pwr_cycle;
    st_d  = st_q;
    if (pwr_cycle) begin
      st_d.stored    = retain ? st_q.stored : 1'b0;
      st_d.last_rung = 1'b0;
      st_d.flow      = 1'b0;
    end else if (scan_en) begin
      st_d.stored    = coil_bit;
      st_d.last_rung = rung_in;
      st_d.flow      = op_is_contact(op) ? contact_flow : rung_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     st_q <= '0;
    else if (ld_en) st_q <= st_d;
  end

  assign rung_out = st_q.flow;
  assign bit_q    = st_q.stored;

  p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!scan_en && !pwr_cycle) |=> ($stable(bit_q) && $stable(rung_out)));

  p_contact_keeps_bit_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (scan_en && !pwr_cycle && op_is_contact(op)) |=> $stable(bit_q));

  p_rise_needs_power_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (scan_en && !pwr_cycle && op == OP_W'(OP_EDGE_UP) && !rung_in) |=> !rung_out);

  p_fall_needs_loss_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (scan_en && !pwr_cycle && op == OP_W'(OP_EDGE_DN) && rung_in) |=> !rung_out);

  p_latch_sets_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (scan_en && !pwr_cycle && op == OP_W'(OP_LATCH) && rung_in) |=> bit_q);

  p_coil_passes_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (scan_en && !pwr_cycle && !op_is_contact(op)) |=> (rung_out == $past(rung_in)));

  p_retained_kept_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_cycle && retain) |=> $stable(bit_q));

  p_volatile_cleared_r11: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_cycle |=> (!rung_out && (bit_q == ($past(retain) & $past(bit_q)))));

endmodule

// File: rtl/ladder_bit_unit.sv
module ladder_bit_unit
  import ladder_pkg::*;
#(
  parameter int LANES       = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  scan_en,
  input  logic                  pwr_cycle,
  input  logic [LANES-1:0]      rung_in,
  input  logic [LANES*OP_W-1:0] opcode,
  input  logic [LANES-1:0]      retain,
  output logic [LANES-1:0]      rung_out,
  output logic [LANES-1:0]      bit_q
);
  localparam int OPV_W = LANES * OP_W;

  logic rst_n_int;

  lad_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [OP_W-1:0] lane_op;
    assign lane_op = opcode[g*OP_W +: OP_W];

    lad_lane u_lane (
      .clk       (clk),
      .rst_n     (rst_n_int),
      .scan_en   (scan_en),
      .pwr_cycle (pwr_cycle),
      .rung_in   (rung_in[g]),
      .op        (lane_op),
      .retain    (retain[g]),
      .rung_out  (rung_out[g]),
      .bit_q     (bit_q[g])
    );
  end

  initial begin
    a_width_r10: assert (OPV_W == $bits(opcode));
  end

endmodule

// File: tb/test_ladder_bit_unit.sv
module test_ladder_bit_unit;
  localparam int L = 4;

  logic           clk;
  logic           rst_n;
  logic           scan_en;
  logic           pwr_cycle;
  logic [L-1:0]   rung_in;
  logic [L*4-1:0] opcode;
  logic [L-1:0]   retain;
  logic [L-1:0]   rung_out;
  logic [L-1:0]   bit_q;

  int errors = 0;
  int checks = 0;
  bit done   = 0;

  bit    m_bit  [L];
  bit    m_prev [L];
  bit    m_out  [L];
  string t_out  [L];
  string t_bit  [L];

  ladder_bit_unit #(.LANES(L)) i_ladder_bit_unit (
    .clk, .rst_n, .scan_en, .pwr_cycle, .rung_in, .opcode, .retain,
    .rung_out, .bit_q
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic check(input string tag, input string what, input bit act, input bit exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0b expected=%0b at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    for (int i = 0; i < L; i++) begin
      check(t_out[i], $sformatf("rung_out[%0d]", i), rung_out[i], m_out[i]);
      check(t_bit[i], $sformatf("bit_q[%0d]", i), bit_q[i], m_bit[i]);
    end
  endtask

  // Behavioural model of one scan for all lanes.
  task automatic model(input bit s, input bit p, input logic [L-1:0] r,
                       input logic [L*4-1:0] ops, input logic [L-1:0] ret);
    for (int i = 0; i < L; i++) begin
      int op = int'(ops[i*4 +: 4]);
      bit ri = r[i];
      if (p) begin
        if (!ret[i]) m_bit[i] = 0;
        m_prev[i] = 0;
        m_out[i]  = 0;
        t_out[i]  = "R11";
        t_bit[i]  = "R11";
      end else if (s) begin
        case (op)
          0: begin m_out[i] = ri && m_bit[i];  t_out[i] = "R3"; t_bit[i] = "R3"; end
          1: begin m_out[i] = ri && !m_bit[i]; t_out[i] = "R4"; t_bit[i] = "R4"; end
          2: begin m_out[i] = ri && !m_prev[i]; t_out[i] = "R5 R12"; t_bit[i] = "R5"; end
          3: begin m_out[i] = !ri && m_prev[i]; t_out[i] = "R6 R12"; t_bit[i] = "R6"; end
          4: begin m_out[i] = ri; m_bit[i] = ri;  t_out[i] = "R10"; t_bit[i] = "R7"; end
          5: begin m_out[i] = ri; m_bit[i] = !ri; t_out[i] = "R10"; t_bit[i] = "R7"; end
          6: begin m_out[i] = ri; if (ri) m_bit[i] = 1; t_out[i] = "R10"; t_bit[i] = "R8"; end
          7: begin m_out[i] = ri; if (ri) m_bit[i] = 0; t_out[i] = "R10"; t_bit[i] = "R8"; end
          8: begin m_out[i] = ri; if (ri && !m_prev[i]) m_bit[i] = 1; t_out[i] = "R10"; t_bit[i] = "R9 R12"; end
          9: begin m_out[i] = ri; if (!ri && m_prev[i]) m_bit[i] = 0; t_out[i] = "R10"; t_bit[i] = "R9 R12"; end
          default: begin m_out[i] = ri; t_out[i] = "R10"; t_bit[i] = "R10"; end
        endcase
        m_prev[i] = ri;
      end else begin
        t_out[i] = "R2";
        t_bit[i] = "R2";
      end
    end
  endtask

  // Called just after a falling edge: drive, advance model, compare at next falling edge.
  task automatic step(input bit s, input bit p, input logic [L-1:0] r,
                      input logic [L*4-1:0] ops, input logic [L-1:0] ret);
    scan_en   = s;
    pwr_cycle = p;
    rung_in   = r;
    opcode    = ops;
    retain    = ret;
    model(s, p, r, ops, ret);
    @(negedge clk);
    compare_all();
  endtask

  function automatic logic [L*4-1:0] all_op(input logic [3:0] o);
    return {L{o}};
  endfunction

  initial begin
    rst_n = 1'b0;
    scan_en = 1'b0; pwr_cycle = 1'b0; rung_in = '0; opcode = '0; retain = '0;
    for (int i = 0; i < L; i++) begin
      m_bit[i] = 0; m_prev[i] = 0; m_out[i] = 0; t_out[i] = "R1"; t_bit[i] = "R1";
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    compare_all();                                   // R1 reset state

    // R1: first scan with power on counts as a rise
    step(1, 0, 4'b1111, all_op(4'd2), '0);
    // R8 latch pattern 0101, then R3 / R4 contacts
    step(1, 0, 4'b0101, all_op(4'd6), '0);
    step(1, 0, 4'b0011, all_op(4'd0), '0);
    step(1, 0, 4'b1111, all_op(4'd1), '0);
    step(1, 0, 4'b1010, all_op(4'd7), '0);
    // R5 / R6 transition contacts over rise, hold, fall
    step(1, 0, 4'b0000, {4'd3, 4'd3, 4'd2, 4'd2}, '0);
    step(1, 0, 4'b1111, {4'd3, 4'd3, 4'd2, 4'd2}, '0);
    step(1, 0, 4'b1111, {4'd3, 4'd3, 4'd2, 4'd2}, '0);
    step(1, 0, 4'b0000, {4'd3, 4'd3, 4'd2, 4'd2}, '0);
    // R7 plain and negated coils
    step(1, 0, 4'b0110, {4'd5, 4'd4, 4'd5, 4'd4}, '0);
    // R9 edge coils, R12 history across opcodes
    step(1, 0, 4'b0000, {4'd9, 4'd9, 4'd8, 4'd8}, '0);
    step(1, 0, 4'b1111, {4'd9, 4'd9, 4'd8, 4'd8}, '0);
    step(1, 0, 4'b1111, {4'd7, 4'd7, 4'd7, 4'd7}, '0);
    step(1, 0, 4'b1111, {4'd9, 4'd9, 4'd8, 4'd8}, '0);
    step(1, 0, 4'b0000, {4'd9, 4'd9, 4'd8, 4'd8}, '0);
    // R2 no scan: inputs move, outputs hold
    step(0, 0, 4'b1111, all_op(4'd4), '0);
    step(0, 0, 4'b1010, all_op(4'd5), '0);
    // R10 undefined opcodes
    step(1, 0, 4'b1111, all_op(4'd6), '0);
    step(1, 0, 4'b0101, {4'd15, 4'd12, 4'd11, 4'd10}, '0);
    step(1, 0, 4'b1010, {4'd14, 4'd13, 4'd10, 4'd15}, '0);
    // R11 power cycle with mixed retain, and with a scan in the same cycle
    step(0, 1, 4'b0000, '0, 4'b0011);
    step(1, 0, 4'b1111, all_op(4'd2), '0);
    step(1, 0, 4'b1111, all_op(4'd6), '0);
    step(1, 1, 4'b0000, all_op(4'd7), 4'b1100);
    step(1, 0, 4'b1111, all_op(4'd8), '0);

    // Random phase
    for (int n = 0; n < 4000; n++) begin
      logic [L*4-1:0] ops;
      for (int i = 0; i < L; i++) ops[i*4 +: 4] = 4'($urandom_range(0, 15));
      step(($urandom_range(0, 9) < 8), ($urandom_range(0, 49) == 0),
           L'($urandom), ops, L'($urandom));
    end

    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule